// File: doc/BRIEF.md
# Single/Double Click Classifier

The block watches a click strobe and a tick strobe, both one-cycle qualifiers on the system clock. A click that arrives while the block is idle opens an observation window. The window lasts a fixed number of ticks, set by the parameter `DELTA`. When the window closes, the block reports whether any further click arrived inside it. It reports this as a one-cycle `single_o` or `double_o` pulse.

Windows never overlap, and only a click can open one. The window boundary is open on the left and closed on the right. The opening click and any tick that coincides with it are not counted. A click or tick on the closing cycle is counted. Extra clicks beyond the second are absorbed without being reported. Debouncing and generation of the tick time base happen upstream.

Top module: `click_classifier`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, `single_o` and `double_o` are low and no window is open.
- R2: A tick while no window is open has no effect. A window opens only on a click while idle.
- R3: A window closes on the `DELTA`-th tick that falls in a cycle strictly after the opening click. A tick in the opening cycle is not counted. The result pulse appears in the cycle after the closing tick is sampled.
- R4: Each closed window produces exactly one pulse, on either `single_o` or `double_o`, and that pulse lasts one cycle. The two outputs are never high together.
- R5: If no click arrives after the opening click up to and including the closing cycle, the pulse is on `single_o`.
- R6: If one or more clicks arrive after the opening cycle within the window, the pulse is on `double_o`. A single pulse is produced however many extra clicks arrive.
- R7: A click in the same cycle as the closing tick counts toward the closing window.
- R8: A click inside an open window does not restart the window or its tick count.
- R9: A click in the closing cycle does not open a new window. A click in the following cycle may open one.
- R10: Asserting reset while a window is open abandons it with no pulse. Counting restarts from zero on the next opening click.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| click_i | input | 1 | One-cycle click strobe |
| tick_i | input | 1 | One-cycle time-base strobe |
| single_o | output | 1 | Pulse: window closed with no further click |
| double_o | output | 1 | Pulse: window closed with a further click |

## Verification
The hardest cases to reach are the coincidences at the window edges. One is a tick in the same cycle as the opening click, which must not be counted. Another is a click on the closing tick, which must count toward the window. A third is a click on the closing cycle, which must not start the next window. The stimulus hits each of these with scripted cycle-exact sequences. One sequence holds both strobes high for many cycles in a row, so that windows close and reopen back to back. Each expected pulse is queued with the exact cycle in which it must appear.

// File: rtl/click_cls_pkg.sv
package click_cls_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  function automatic int unsigned cnt_width(input int unsigned delta);
    return (delta > 1) ? $clog2(delta) : 1;
  endfunction
endpackage

// File: rtl/click_window.sv
module click_window
  import click_cls_pkg::*;
#(
  parameter int unsigned DELTA = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic click_i,
  input  logic tick_i,
  output logic start_o,
  output logic close_o,
  output logic open_o
);
  localparam int unsigned CntW = cnt_width(DELTA);
  localparam logic [CntW-1:0] LastCnt = CntW'(DELTA - 1);

  win_state_e      state_q;
  logic [CntW-1:0] cnt_q;

  assign open_o  = (state_q == WIN_OPEN);
  assign start_o = (state_q == WIN_IDLE) && click_i;
  assign close_o = open_o && tick_i && (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
    end else if (start_o) begin
      state_q <= WIN_OPEN;
      cnt_q   <= '0;
    end else if (open_o && tick_i) begin
      if (cnt_q == LastCnt) begin
        state_q <= WIN_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LastCnt);
  a_r2_open_needs_click: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(click_i));
  a_r3_fresh_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> cnt_q == '0);
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !tick_i) |=> (open_o && $stable(cnt_q)));
  a_r9_close_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !open_o);
endmodule

// File: rtl/click_flag.sv
module click_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic click_i,
  input  logic start_i,
  input  logic open_i,
  output logic seen_o
);
  logic extra_q;

  // clicks on the closing cycle are included via the combinational term
  assign seen_o = extra_q || (open_i && click_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                extra_q <= 1'b0;
    else if (start_i)           extra_q <= 1'b0;
    else if (open_i && click_i) extra_q <= 1'b1;
  end

  a_r6_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_i && click_i) |=> extra_q);
  a_r5_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !extra_q);
endmodule

// File: rtl/click_result.sv
module click_result (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic close_i,
  input  logic seen_i,
  output logic single_o,
  output logic double_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_o <= 1'b0;
      double_o <= 1'b0;
    end else begin
      single_o <= close_i && !seen_i;
      double_o <= close_i && seen_i;
    end
  end

  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(single_o && double_o));
  a_r4_single_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_o |=> !single_o);
  a_r4_double_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    double_o |=> !double_o);
  a_r3_pulse_after_close: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> (single_o || double_o));
endmodule

// File: rtl/click_classifier.sv
module click_classifier #(
  parameter int unsigned DELTA = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic click_i,
  input  logic tick_i,
  output logic single_o,
  output logic double_o
);
  logic start, close, open_w, seen;

  initial begin
    a_delta_min: assert (DELTA >= 1);
  end

  click_window #(.DELTA(DELTA)) u_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .click_i (click_i),
    .tick_i  (tick_i),
    .start_o (start),
    .close_o (close),
    .open_o  (open_w)
  );

  click_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .click_i (click_i),
    .start_i (start),
    .open_i  (open_w),
    .seen_o  (seen)
  );

  click_result u_result (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .close_i  (close),
    .seen_i   (seen),
    .single_o (single_o),
    .double_o (double_o)
  );
endmodule

// File: tb/click_classifier_tb_top.sv
module click_classifier_tb_top;
  localparam int unsigned DELTA = 3;

  typedef struct {
    logic  dbl;
    int    cyc;
    string req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic click_i = 1'b0;
  logic tick_i = 1'b0;
  logic single_o, double_o;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  click_classifier #(.DELTA(DELTA)) dut_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .click_i  (click_i),
    .tick_i   (tick_i),
    .single_o (single_o),
    .double_o (double_o)
  );

  task automatic drive(input logic c, input logic t);
    @(negedge clk_i);
    click_i = c;
    tick_i  = t;
  endtask

  // call right after the drive() of the closing cycle
  task automatic expect_res(input logic dbl, input string req);
    exp_t e;
    e.dbl = dbl;
    e.cyc = cyc + 1;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  task automatic pulse_reset(input string req);
    @(negedge clk_i);
    rst_ni  = 1'b0;
    click_i = 1'b0;
    tick_i  = 1'b0;
    @(negedge clk_i);
    n_chk++;
    if (single_o || double_o) begin
      n_fail++;
      $display("FAIL %s: outputs in reset single=%0b double=%0b expected 0 0",
               req, single_o, double_o);
    end
    rst_ni = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (single_o || double_o) begin
        n_chk++;
        if (single_o && double_o) begin
          n_fail++;
          $display("FAIL R4: both outputs high at cycle %0d, expected one", cyc);
          if (exp_q.size() > 0) void'(exp_q.pop_front());
        end else if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R2: unexpected pulse double=%0b at cycle %0d, expected none",
                   double_o, cyc);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (e.cyc != cyc || e.dbl != double_o) begin
            n_fail++;
            $display("FAIL %s: pulse double=%0b at cycle %0d, expected double=%0b at cycle %0d",
                     e.req, double_o, cyc, e.dbl, e.cyc);
          end
        end
      end else if (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        n_fail++;
        $display("FAIL %s: no pulse at cycle %0d, expected double=%0b at cycle %0d",
                 e.req, cyc, e.dbl, e.cyc);
      end
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk_i);
    n_chk++;
    if (single_o || double_o) begin
      n_fail++;
      $display("FAIL R1: single=%0b double=%0b in reset, expected 0 0", single_o, double_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_chk++;
    if (single_o || double_o) begin
      n_fail++;
      $display("FAIL R1: single=%0b double=%0b after release, expected 0 0",
               single_o, double_o);
    end

    // R2: ticks while idle do nothing
    for (int i = 0; i < 5; i++) drive(1'b0, 1'b1);
    idle(2);

    // R3 R5: tick on opening cycle excluded, single on third later tick
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    expect_res(1'b0, "R3_R5");
    idle(3);

    // R6 R8: clicks inside window, no restart
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    expect_res(1'b1, "R6_R8");
    idle(3);

    // R7 R9: click on closing tick counts and does not reopen
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b1);
    expect_res(1'b1, "R7");
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b1);
    idle(2);

    // R9: new window after close behaves normally
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    expect_res(1'b0, "R9");
    idle(3);

    // R9 R6: both strobes held high, windows close and reopen back to back
    drive(1'b1, 1'b1);
    for (int w = 0; w < 3; w++) begin
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b1);
      drive(1'b1, 1'b1);
      expect_res(1'b1, "R9_back_to_back");
      if (w < 2) drive(1'b1, 1'b1);
    end
    idle(3);

    // R6: many extra clicks give a single pulse
    drive(1'b1, 1'b0);
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    expect_res(1'b1, "R6");
    idle(3);

    // R10: reset mid-window abandons it, count restarts
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    pulse_reset("R10");
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    expect_res(1'b0, "R10");
    idle(5);

    // all expected pulses consumed
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R4: %0d pulses outstanding, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule